// File: doc/BRIEF.md
# Exclusive Access Monitor

This block decides whether a store-exclusive may write memory. Requesters first claim a reservation with a load-exclusive, then try the paired store-exclusive. Each requester has a local reservation, which is one valid bit per requester. It also has one global tag for pages that carry the shared attribute. A clear operation drops both reservations of one requester.

Every store-exclusive gets a registered response one cycle later. The response holds a status bit (0 = stored, 1 = refused), a memory write enable and a byte-lane mask for one 8-byte bus beat. The block accepts one request per cycle with no stall. Tag updates made at one clock edge are seen by the request in the next cycle.

Address tags are kept at granule resolution (`GRAN_LG2`, 8 bytes by default). Two addresses in the same granule therefore reserve and match each other.

Top module: `excl_monitor`

## Requirements
- R1: A store-exclusive (op code 1) with the shared flag low succeeds when the requester holds a local reservation, for any address. It responds with status 0 and write enable 1, and it clears that local reservation.
- R2: A store-exclusive with the shared flag low and no local reservation responds with status 0 → 1, meaning status 1, write enable 0 and byte mask 0.
- R3: A store-exclusive with the shared flag high succeeds (status 0, write enable 1) when the requester's global tag is valid and holds the store's granule. On success it clears that requester's global tag and its local reservation.
- R4: A store-exclusive that fails leaves all reservations unchanged.
- R5: Tags compare the address with its low `GRAN_LG2` bits dropped, so any two addresses in one 8-byte granule match.
- R6: A load-exclusive (op code 0) sets the requester's local reservation. With the shared flag high it also writes the granule into that requester's global tag, replacing any older tag. With the shared flag low it invalidates that requester's global tag.
- R7: A successful shared store-exclusive invalidates the global tag of every other requester that holds the same granule.
- R8: A clear operation (op code 2) invalidates the local reservation and the global tag of the named requester only. Other requesters keep theirs.
- R9: While rst_ni is low, all outputs are 0 and every reservation is cleared.
- R10: rsp_valid_o is 1 exactly in the cycle after an accepted store-exclusive. Load, clear, op code 3 and idle cycles give rsp_valid_o = 0 in the next cycle. Back-to-back requests are taken every cycle.
- R11: On success, mem_be_o depends on the size code and on addr[2:0] rounded down to the access alignment. The size codes are 0 = byte (one bit at the offset), 1 = halfword (3 shifted), 2 = word (0xF shifted) and 3 = doubleword (0xFF). On failure mem_be_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 2 | 0 load-exclusive, 1 store-exclusive, 2 clear, 3 none |
| req_id_i | input | ID_W | Requester number |
| req_addr_i | input | ADDR_W | Byte address |
| req_size_i | input | 2 | 0 byte, 1 half, 2 word, 3 doubleword |
| req_shared_i | input | 1 | Page carries the shared attribute |
| rsp_valid_o | output | 1 | Store-exclusive response valid |
| rsp_status_o | output | 1 | 0 stored, 1 refused |
| mem_we_o | output | 1 | Memory write enable |
| mem_be_o | output | 8 | Byte-lane enables for the write |

## Verification
Several properties are checked on every cycle:
- A response follows each store-exclusive and no other request.
- Write enable and status are always opposite.
- The byte mask is non-zero exactly when the write is enabled.
- A non-shared store with no local reservation always fails.
- A clear empties the named local entry.
- A winning shared store empties every global tag holding its granule.

Only the bench's sequences show the effects that span several operations. These are:
- granule-level matching;
- a newer reservation replacing an older one;
- a winning store clearing another requester's reservation;
- a clear leaving other requesters untouched;
- a failed store keeping the reservations it did not use.

// File: rtl/excl_pkg.sv
package excl_pkg;
  typedef enum logic [1:0] {
    OP_LDX  = 2'd0,
    OP_STX  = 2'd1,
    OP_CLRX = 2'd2,
    OP_NONE = 2'd3
  } excl_op_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } excl_size_e;

  localparam int unsigned BUS_BYTES = 8;
  localparam int unsigned OFF_W     = $clog2(BUS_BYTES);
endpackage

// File: rtl/excl_local_mon.sv
module excl_local_mon #(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned ID_W    = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,
  input  logic            clr_i,
  input  logic [ID_W-1:0] id_i,
  output logic            hit_o
);
  logic [NUM_REQ-1:0] vld_q;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          vld_q[g] <= 1'b0;
      else if (id_i == ID_W'(g) && set_i)   vld_q[g] <= 1'b1;
      else if (id_i == ID_W'(g) && clr_i)   vld_q[g] <= 1'b0;
    end
  end

  assign hit_o = vld_q[id_i];

  // R8: a clear leaves the named entry empty
  a_r8_local_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !vld_q[$past(id_i)]);
endmodule

// File: rtl/excl_global_mon.sv
module excl_global_mon #(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned ID_W    = 2,
  parameter int unsigned TAG_W   = 29
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             drop_i,
  input  logic             kill_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o
);
  logic [NUM_REQ-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [NUM_REQ];

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_ent
    logic own;
    assign own = (id_i == ID_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
      end else if (own && set_i) begin
        vld_q[g] <= 1'b1;
        tag_q[g] <= tag_i;
      end else if ((own && drop_i) || (kill_i && vld_q[g] && tag_q[g] == tag_i)) begin
        vld_q[g] <= 1'b0;
      end
    end

    // R7: a winning shared store empties every matching tag
    a_r7_kill_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (kill_i && vld_q[g] && tag_q[g] == tag_i) |=> !vld_q[g]);
  end

  assign hit_o = vld_q[id_i] && (tag_q[id_i] == tag_i);
endmodule

// File: rtl/excl_lane_mask.sv
module excl_lane_mask
  import excl_pkg::*;
(
  input  logic [1:0]       size_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             en_i,
  output logic [BUS_BYTES-1:0] be_o
);
  logic [BUS_BYTES-1:0] raw;

  always_comb begin
    unique case (excl_size_e'(size_i))
      SZ_B:    raw = BUS_BYTES'(8'h01 << off_i);
      SZ_H:    raw = BUS_BYTES'(8'h03 << {off_i[OFF_W-1:1], 1'b0});
      SZ_W:    raw = BUS_BYTES'(8'h0F << {off_i[OFF_W-1], 2'b00});
      default: raw = '1;
    endcase
    be_o = en_i ? raw : '0;
  end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned NUM_REQ  = 4,
  parameter int unsigned GRAN_LG2 = 3,
  localparam int unsigned ID_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int unsigned TAG_W   = ADDR_W - GRAN_LG2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [1:0]           req_op_i,
  input  logic [ID_W-1:0]      req_id_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [1:0]           req_size_i,
  input  logic                 req_shared_i,
  output logic                 rsp_valid_o,
  output logic                 rsp_status_o,
  output logic                 mem_we_o,
  output logic [BUS_BYTES-1:0] mem_be_o
);
  logic [TAG_W-1:0] gran;
  logic is_ld, is_st, is_clr;
  logic loc_hit, glb_hit, pass;
  logic [BUS_BYTES-1:0] be_d;

  assign gran   = req_addr_i[ADDR_W-1:GRAN_LG2];
  assign is_ld  = req_valid_i && (excl_op_e'(req_op_i) == OP_LDX);
  assign is_st  = req_valid_i && (excl_op_e'(req_op_i) == OP_STX);
  assign is_clr = req_valid_i && (excl_op_e'(req_op_i) == OP_CLRX);
  assign pass   = is_st && (req_shared_i ? glb_hit : loc_hit);

  excl_local_mon #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) u_local (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (is_ld),
    .clr_i  (is_clr || pass),
    .id_i   (req_id_i),
    .hit_o  (loc_hit)
  );

  excl_global_mon #(.NUM_REQ(NUM_REQ), .ID_W(ID_W), .TAG_W(TAG_W)) u_global (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (is_ld && req_shared_i),
    .drop_i (is_clr || (is_ld && !req_shared_i)),
    .kill_i (pass && req_shared_i),
    .id_i   (req_id_i),
    .tag_i  (gran),
    .hit_o  (glb_hit)
  );

  excl_lane_mask u_mask (
    .size_i (req_size_i),
    .off_i  (req_addr_i[OFF_W-1:0]),
    .en_i   (pass),
    .be_o   (be_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_status_o <= 1'b0;
      mem_we_o     <= 1'b0;
      mem_be_o     <= '0;
    end else begin
      rsp_valid_o  <= is_st;
      rsp_status_o <= is_st && !pass;
      mem_we_o     <= pass;
      mem_be_o     <= be_d;
    end
  end

  a_r10_rsp_after_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_st |=> rsp_valid_o);
  a_r10_no_rsp_otherwise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_st |=> !rsp_valid_o);
  a_r2_no_rsv_fails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_st && !req_shared_i && !loc_hit) |=> (rsp_status_o && !mem_we_o));
  a_r1_we_vs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (mem_we_o != rsp_status_o));
  a_r11_be_with_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o == (mem_be_o != '0));
  a_r11_be_pow2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($countones(mem_be_o) inside {1, 2, 4, 8}));
endmodule

// File: tb/sim_excl_monitor.sv
`timescale 1ns/1ps
module sim_excl_monitor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [1:0] op = 2'd3;
  logic [1:0] id = '0;
  logic [31:0] addr = '0;
  logic [1:0] size = '0;
  logic       shared = 1'b0;
  logic       rv, st, we;
  logic [7:0] be;
  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  excl_monitor u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_op_i(op),
    .req_id_i(id), .req_addr_i(addr), .req_size_i(size), .req_shared_i(shared),
    .rsp_valid_o(rv), .rsp_status_o(st), .mem_we_o(we), .mem_be_o(be)
  );

  // fields: rq(4) op(2) id(2) addr(16) sh(1) sz(2) | rv st we be(8)
  localparam int NV = 30;
  localparam logic [37:0] VEC [NV] = '{
    {4'd2,  2'd1, 2'd0, 16'h0100, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 8'h00}, // R2
    {4'd6,  2'd0, 2'd0, 16'h0100, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 8'h00}, // R6
    {4'd1,  2'd1, 2'd0, 16'h0200, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 8'h01}, // R1
    {4'd1,  2'd1, 2'd0, 16'h0200, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 8'h00}, // R1 cleared
    {4'd6,  2'd0, 2'd1, 16'h0300, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 8'h00},
    {4'd5,  2'd1, 2'd1, 16'h0304, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 8'hF0}, // R5
    {4'd3,  2'd1, 2'd1, 16'h0300, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 8'h00}, // R3
    {4'd6,  2'd0, 2'd1, 16'h0400, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0, 8'h00},
    {4'd4,  2'd1, 2'd1, 16'h0408, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 8'h00}, // R4
    {4'd4,  2'd1, 2'd1, 16'h0400, 1'b1, 2'd3, 1'b1, 1'b0, 1'b1, 8'hFF}, // R4
    {4'd6,  2'd0, 2'd2, 16'h0500, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 8'h00},
    {4'd6,  2'd0, 2'd3, 16'h0502, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 8'h00},
    {4'd11, 2'd1, 2'd3, 16'h0506, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 8'hC0}, // R11
    {4'd7,  2'd1, 2'd2, 16'h0500, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 8'h00}, // R7
    {4'd6,  2'd0, 2'd2, 16'h0600, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 8'h00},
    {4'd6,  2'd0, 2'd2, 16'h0700, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 8'h00},
    {4'd6,  2'd1, 2'd2, 16'h0600, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 8'h00}, // R6 replaced
    {4'd11, 2'd1, 2'd2, 16'h0703, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 8'h08}, // R11
    {4'd6,  2'd0, 2'd0, 16'h0800, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 8'h00},
    {4'd8,  2'd2, 2'd0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00}, // R8
    {4'd8,  2'd1, 2'd0, 16'h0800, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 8'h00}, // R8
    {4'd8,  2'd1, 2'd0, 16'h0800, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 8'h00}, // R8
    {4'd6,  2'd0, 2'd1, 16'h0900, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 8'h00},
    {4'd8,  2'd2, 2'd2, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00},
    {4'd8,  2'd1, 2'd1, 16'h0900, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 8'h0F}, // R8 other kept
    {4'd3,  2'd1, 2'd1, 16'h0900, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 8'h00}, // R3 local cleared
    {4'd6,  2'd0, 2'd3, 16'h0A00, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 8'h00},
    {4'd6,  2'd0, 2'd3, 16'h0B00, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 8'h00},
    {4'd6,  2'd1, 2'd3, 16'h0A00, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 8'h00}, // R6 global dropped
    {4'd4,  2'd1, 2'd3, 16'h0B02, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 8'h0C}  // R4 local kept
  };

  task automatic send(input logic [1:0] o, input logic [1:0] i, input logic [15:0] a,
                      input logic s, input logic [1:0] z);
    @(negedge clk);
    valid = 1'b1; op = o; id = i; addr = {16'h0, a}; shared = s; size = z;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input int rq, input string what, input logic [10:0] got, input logic [10:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: got rv/st/we/be=%b expected %b", rq, what, got, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(9, "outputs in reset", {rv, st, we, be}, 11'b0); // R9
    @(negedge clk) rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [37:0] v;
      v = VEC[k];
      send(v[33:32], v[31:30], v[29:14], v[13], v[12:11]);
      check(int'(v[37:34]), $sformatf("vector %0d", k), {rv, st, we, be}, v[10:0]);
    end

    // R10: idle and op 3 produce no response
    @(negedge clk) valid = 1'b0;
    @(posedge clk); #1 check(10, "idle", {rv, st, we, be}, 11'b0);
    send(2'd0, 2'd0, 16'h0C00, 1'b1, 2'd2);
    send(2'd3, 2'd0, 16'h0C00, 1'b1, 2'd2);
    check(10, "op 3 no response", {rv, st, we, be}, 11'b0);
    send(2'd1, 2'd0, 16'h0C00, 1'b1, 2'd2);
    check(10, "op 3 no effect", {rv, st, we, be}, {3'b101, 8'h0F});

    // R9: reset mid-run drops reservations
    send(2'd0, 2'd1, 16'h0D00, 1'b1, 2'd3);
    send(2'd0, 2'd1, 16'h0D00, 1'b1, 2'd3);
    @(negedge clk) valid = 1'b0; rst_n = 1'b0;
    #1 check(9, "async reset clears outputs", {rv, st, we, be}, 11'b0);
    @(negedge clk) rst_n = 1'b1;
    send(2'd1, 2'd1, 16'h0D00, 1'b1, 2'd3);
    check(9, "shared tag gone after reset", {rv, st, we, be}, {3'b110, 8'h00});
    send(2'd1, 2'd1, 16'h0D00, 1'b0, 2'd3);
    check(9, "local gone after reset", {rv, st, we, be}, {3'b110, 8'h00});

    @(negedge clk) valid = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule